// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Receive Queue

This block is the receive half of a classic asynchronous serial port. It watches a serial line, finds character frames with a 16x oversampling enable, and samples each bit at its middle. Every finished character goes into a 16-entry receive queue. Three flag bits travel with it: parity error, framing error and break. Software reads that queue and a receive-status byte.

The status byte reports several things. It shows whether data is waiting and whether a character was lost to a full queue. It shows the three flags of the character at the head of the queue. A sticky summary bit records that some flagged character has arrived. A long low line (a break) produces exactly one all-zero entry, however long it lasts. After a bad stop bit the receiver does not hunt for a new start edge. It treats that low sample as the start of the next character.

Frame shape is set by configuration inputs: 5 to 8 data bits, optional even or odd parity, and one or two stop bits. Only the first stop bit is checked for framing. The oversampling enable comes from an external baud generator.

Top module: `serial_rx_tagged`

## Requirements
- R1: Characters arrive LSB first after a low start bit. `cfg_dbits` selects the data length (0=5, 1=6, 2=7, 3=8 bits). Data is stored right-aligned with unused upper bits zero, and entries are read out in arrival order.
- R2: When `cfg_par_en` is 1, one parity bit follows the data. The expected value is the XOR of the data bits when `cfg_par_odd` is 0, and its inverse when `cfg_par_odd` is 1. A mismatch sets that entry's parity flag.
- R3: If the first stop sample is low, the entry gets its framing flag. That same low sample is then taken as an already-confirmed start bit, and the next data bit is sampled one bit time later.
- R4: A frame in which every sample is low, including the first stop bit (and also the second stop bit when `cfg_stop2` is 1), queues exactly one entry. That entry has data 0 and framing and break flags set, and its parity flag follows R2. Nothing more is queued until the line returns high. With `cfg_stop2`=1, a high second stop after such a frame gives data 0 with only the framing flag.
- R5: The queue holds 16 entries. A character that completes while the queue is full is discarded and sets the overrun bit. A status read clears the overrun bit.
- R6: `lsr` bit 0 is data ready (queue not empty), bit 1 overrun, bit 2 parity, bit 3 framing, bit 4 break (bits 2 to 4 are the head entry's flags, 0 when the queue is empty), bit 7 error summary, and bits 5 and 6 are 0.
- R7: The error summary bit sets when a flagged entry enters the queue. A status read clears it only if no entry still in the queue is flagged.
- R8: A one-cycle `rx_pop` removes the head entry. A pop on an empty queue has no effect.
- R9: A low level that is high again at the middle of the start bit queues nothing.
- R10: After reset the queue is empty and `lsr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | 16x bit-rate sample enable |
| rxd | input | 1 | Serial input (idle high) |
| cfg_dbits | input | 2 | Data length select, 0..3 = 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop2 | input | 1 | Two stop bits |
| rx_pop | input | 1 | Remove head entry |
| rx_data | output | 8 | Head entry data (0 when empty) |
| rx_pe | output | 1 | Head entry parity flag |
| rx_fe | output | 1 | Head entry framing flag |
| rx_bi | output | 1 | Head entry break flag |
| lsr_rd | input | 1 | Status read strobe |
| lsr | output | 8 | Receive status byte |

## Verification
The assertions check these rules on every cycle:
- a break entry is always zero data carrying a framing flag, and no second entry appears while the break lasts;
- a full queue refuses writes and sets overrun;
- a pop on an empty queue leaves it empty;
- the summary bit stays high while any flagged entry is queued.

Some behaviours can only be shown by the bench's scenarios:
- bit order and data-length alignment;
- the parity sense;
- resynchronisation after a bad stop bit;
- the two-stop-bit break rule;
- rejection of a false start;
- the order of entries across an overrun.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       pe;
    logic       fe;
    logic       bi;
  } srx_entry_t;

  // index of the last data bit for a length select (0..3 -> 5..8 bits)
  function automatic logic [2:0] last_idx(input logic [1:0] sel);
    return 3'd4 + {1'b0, sel};
  endfunction

  // expected parity bit value; unused upper data bits are zero
  function automatic logic exp_parity(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  function automatic logic has_error(input srx_entry_t e);
    return e.pe | e.fe | e.bi;
  endfunction
endpackage

// File: rtl/srx_deser.sv
module srx_deser
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic [1:0] cfg_dbits,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  output logic       frame_done,
  output srx_entry_t frame_entry
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_STOP2, S_BRK} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [2:0]      bidx;
  logic [7:0]      shreg;
  logic            par_bad, all_low;
  logic [1:0]      sync;
  logic            rx_s;
  logic            push_q;
  srx_entry_t      entry_q;

  assign rx_s        = sync[1];
  assign frame_done  = push_q;
  assign frame_entry = entry_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bidx <= '0; shreg <= '0;
      par_bad <= 1'b0; all_low <= 1'b0; push_q <= 1'b0; entry_q <= '0;
    end else begin
      push_q <= 1'b0;
      if (os_tick) begin
        case (st)
          S_IDLE: if (!rx_s) begin st <= S_START; cnt <= '0; end
          S_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              if (!rx_s) begin
                st <= S_DATA; bidx <= '0; shreg <= '0; all_low <= 1'b1; par_bad <= 1'b0;
              end else st <= S_IDLE;
            end else cnt <= cnt + CW'(1);
          end
          S_DATA: begin
            if (cnt == LAST) begin
              cnt <= '0;
              shreg[bidx] <= rx_s;
              if (rx_s) all_low <= 1'b0;
              if (bidx == last_idx(cfg_dbits)) st <= cfg_par_en ? S_PAR : S_STOP;
              else bidx <= bidx + 3'd1;
            end else cnt <= cnt + CW'(1);
          end
          S_PAR: begin
            if (cnt == LAST) begin
              cnt <= '0;
              par_bad <= (rx_s != exp_parity(shreg, cfg_par_odd));
              if (rx_s) all_low <= 1'b0;
              st <= S_STOP;
            end else cnt <= cnt + CW'(1);
          end
          S_STOP: begin
            if (cnt == LAST) begin
              cnt <= '0;
              if (rx_s) begin
                push_q <= 1'b1; entry_q <= '{data: shreg, pe: par_bad, fe: 1'b0, bi: 1'b0};
                st <= S_IDLE;
              end else if (all_low) begin
                if (cfg_stop2) st <= S_STOP2;
                else begin
                  push_q <= 1'b1; entry_q <= '{data: 8'h00, pe: par_bad, fe: 1'b1, bi: 1'b1};
                  st <= S_BRK;
                end
              end else begin
                // low stop sample becomes the next start bit
                push_q <= 1'b1; entry_q <= '{data: shreg, pe: par_bad, fe: 1'b1, bi: 1'b0};
                st <= S_DATA; bidx <= '0; shreg <= '0; all_low <= 1'b1; par_bad <= 1'b0;
              end
            end else cnt <= cnt + CW'(1);
          end
          S_STOP2: begin
            if (cnt == LAST) begin
              cnt <= '0;
              push_q <= 1'b1;
              if (rx_s) begin
                entry_q <= '{data: 8'h00, pe: par_bad, fe: 1'b1, bi: 1'b0};
                st <= S_IDLE;
              end else begin
                entry_q <= '{data: 8'h00, pe: par_bad, fe: 1'b1, bi: 1'b1};
                st <= S_BRK;
              end
            end else cnt <= cnt + CW'(1);
          end
          S_BRK: if (rx_s) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_BREAK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_q && entry_q.bi) |-> (entry_q.fe && entry_q.data == 8'h00)); // R4
  AST_BREAK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BRK) |=> !push_q); // R4
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  srx_entry_t wdata,
  input  logic       rd,
  output srx_entry_t head,
  output logic       empty,
  output logic       wr_ok,
  output logic       rd_ok,
  output logic       drop
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  srx_entry_t    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          full;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign wr_ok = wr && !full;
  assign rd_ok = rd && !empty;
  assign drop  = wr && full;
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (wr_ok) wp <= wp + AW'(1);
      if (rd_ok) rp <= rp + AW'(1);
      count <= count + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && full && !rd) |=> $stable(count)); // R5
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && empty && !wr) |=> empty); // R8
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R5
endmodule

// File: rtl/srx_status.sv
module srx_status
  import srx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_push,
  input  logic       push_err,
  input  logic       drop,
  input  logic       pop_ok,
  input  srx_entry_t head,
  input  logic       empty,
  input  logic       lsr_rd,
  output logic [7:0] lsr
);
  localparam int EW = $clog2(DEPTH + 1);

  logic [EW-1:0] err_cnt;
  logic          oe, err_sum, pop_err;

  assign pop_err = pop_ok && has_error(head);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe <= 1'b0; err_sum <= 1'b0; err_cnt <= '0;
    end else begin
      if (drop)        oe <= 1'b1;
      else if (lsr_rd) oe <= 1'b0;
      err_cnt <= err_cnt + EW'(acc_push && push_err) - EW'(pop_err);
      if (acc_push && push_err)           err_sum <= 1'b1;
      else if (lsr_rd && err_cnt == '0)   err_sum <= 1'b0;
    end
  end

  always_comb begin
    lsr    = '0;
    lsr[0] = !empty;
    lsr[1] = oe;
    lsr[2] = !empty && head.pe;
    lsr[3] = !empty && head.fe;
    lsr[4] = !empty && head.bi;
    lsr[7] = err_sum;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != '0) |-> err_sum); // R7
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> lsr[1]); // R5
endmodule

// File: rtl/serial_rx_tagged.sv
module serial_rx_tagged
  import srx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic [1:0] cfg_dbits,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  input  logic       rx_pop,
  output logic [7:0] rx_data,
  output logic       rx_pe,
  output logic       rx_fe,
  output logic       rx_bi,
  input  logic       lsr_rd,
  output logic [7:0] lsr
);
  logic       frame_done, empty, wr_ok, rd_ok, drop;
  srx_entry_t frame_entry, head;

  srx_deser #(.OSR(OSR)) u_deser (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .cfg_dbits(cfg_dbits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .frame_done(frame_done), .frame_entry(frame_entry));

  srx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr(frame_done), .wdata(frame_entry), .rd(rx_pop),
    .head(head), .empty(empty), .wr_ok(wr_ok), .rd_ok(rd_ok), .drop(drop));

  srx_status #(.DEPTH(DEPTH)) u_status (
    .clk(clk), .rst_n(rst_n), .acc_push(wr_ok), .push_err(has_error(frame_entry)),
    .drop(drop), .pop_ok(rd_ok), .head(head), .empty(empty), .lsr_rd(lsr_rd), .lsr(lsr));

  assign rx_data = empty ? 8'h00 : head.data;
  assign rx_pe   = !empty && head.pe;
  assign rx_fe   = !empty && head.fe;
  assign rx_bi   = !empty && head.bi;

  AST_DR_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !rx_pop) |=> lsr[0]); // R6
endmodule

// File: tb/serial_rx_tagged_tb.sv
module serial_rx_tagged_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, os_tick, rxd, cfg_par_en, cfg_par_odd, cfg_stop2, rx_pop, lsr_rd;
  logic [1:0] cfg_dbits;
  logic [7:0] rx_data, lsr;
  logic       rx_pe, rx_fe, rx_bi;

  serial_rx_tagged u_dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .cfg_dbits(cfg_dbits),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_pe(rx_pe), .rx_fe(rx_fe), .rx_bi(rx_bi),
    .lsr_rd(lsr_rd), .lsr(lsr));

  always_ff @(posedge clk) begin
    if (!rst_n) os_tick <= 1'b0;
    else        os_tick <= ~os_tick;
  end

  localparam int BITCLK = 32;  // 16 ticks, one tick every 2 clocks
  typedef struct { int data; bit pe; bit fe; bit bi; } ent_t;
  ent_t q[$];
  bit   m_oe, m_err, steady;
  int   n_run, n_fail, mism;

  function automatic logic [7:0] exp_lsr();
    logic [7:0] v;
    v = '0;
    if (q.size() > 0) begin
      v[0] = 1'b1; v[2] = q[0].pe; v[3] = q[0].fe; v[4] = q[0].bi;
    end
    v[1] = m_oe; v[7] = m_err;
    return v;
  endfunction

  function automatic bit par_of(int d, int n, bit odd);
    int ones = 0;
    for (int i = 0; i < n; i++) if (d[i]) ones++;
    return ((ones % 2) == 1) ? !odd : odd;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic mpush(int d, bit pe, bit fe, bit bi);
    ent_t e;
    e.data = d; e.pe = pe; e.fe = fe; e.bi = bi;
    if (q.size() == 16) m_oe = 1'b1;
    else begin
      q.push_back(e);
      if (pe || fe || bi) m_err = 1'b1;
    end
  endtask

  task automatic drive_bit(bit b);
    rxd = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send_bits(int v, int n);
    for (int i = 0; i < n; i++) drive_bit(v[i]);
  endtask

  // one well-formed frame with current config; bad_par flips the parity bit
  task automatic send_char(int d, bit bad_par);
    int n = 5 + int'(cfg_dbits);
    int dm = d & ((1 << n) - 1);
    drive_bit(1'b0);
    send_bits(dm, n);
    if (cfg_par_en) drive_bit(par_of(dm, n, cfg_par_odd) ^ bad_par);
    drive_bit(1'b1);
    if (cfg_stop2) drive_bit(1'b1);
    mpush(dm, bad_par && cfg_par_en, 1'b0, 1'b0);
  endtask

  task automatic settle();
    steady = 1'b1;
    repeat (40) @(negedge clk);
    steady = 1'b0;
  endtask

  task automatic do_pop();
    rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
    if (q.size() > 0) void'(q.pop_front());
  endtask

  task automatic do_read();
    bit flagged = 1'b0;
    lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;
    m_oe = 1'b0;
    foreach (q[i]) if (q[i].pe || q[i].fe || q[i].bi) flagged = 1'b1;
    if (!flagged) m_err = 1'b0;
  endtask

  task automatic check_head(string tag);
    chk({tag, " lsr"}, int'(lsr), int'(exp_lsr()));
    chk({tag, " data"}, int'(rx_data), (q.size() > 0) ? q[0].data : 0);
    chk({tag, " flags"}, int'({rx_pe, rx_fe, rx_bi}),
        (q.size() > 0) ? int'({q[0].pe, q[0].fe, q[0].bi}) : 0);
  endtask

  task automatic head_and_pop(string tag);
    check_head(tag);
    do_pop();
  endtask

  task automatic drain();
    while (q.size() > 0) do_pop();
    do_read();
  endtask

  // per-clock comparison of the status byte against the model while quiet
  always @(negedge clk) begin
    if (steady && rst_n && (lsr !== exp_lsr())) mism++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1; rx_pop = 1'b0; lsr_rd = 1'b0;
    cfg_dbits = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_stop2 = 1'b0;
    m_oe = 0; m_err = 0; steady = 0; n_run = 0; n_fail = 0; mism = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 reset lsr", int'(lsr), 0);
    chk("R10 reset data", int'(rx_data), 0);

    // R1 plain 8-bit, then 5-bit right-aligned
    send_char(8'hA5, 0); drive_bit(1); settle();
    head_and_pop("R1 8bit A5");
    cfg_dbits = 2'd0;
    send_char(8'h16, 0); drive_bit(1); settle();
    head_and_pop("R1 5bit");
    cfg_dbits = 2'd1;
    send_char(8'h2B, 0); send_char(8'h14, 0); drive_bit(1); settle();
    head_and_pop("R1 6bit first"); head_and_pop("R1 6bit second");
    chk("R6 empty lsr", int'(lsr), int'(exp_lsr()));

    // R2 parity even/odd, good and bad
    cfg_dbits = 2'd2; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send_char(8'h55, 0); send_char(8'h13, 1); drive_bit(1);
    cfg_par_odd = 1'b1;
    send_char(8'h40, 0); send_char(8'h7F, 1); drive_bit(1); settle();
    head_and_pop("R2 even good"); head_and_pop("R2 even bad");
    head_and_pop("R2 odd good"); head_and_pop("R2 odd bad");
    drain();

    // R9 false start
    cfg_dbits = 2'd3; cfg_par_en = 1'b0;
    rxd = 1'b0; repeat (6) @(negedge clk); rxd = 1'b1;
    drive_bit(1); drive_bit(1); settle();
    chk("R9 false start no entry", int'(lsr), int'(exp_lsr()));

    // R3 framing error with resync on the low stop sample
    drive_bit(0); send_bits(8'h3C, 8); drive_bit(0);
    mpush(8'h3C, 0, 1, 0);
    send_bits(8'h81, 8); drive_bit(1); mpush(8'h81, 0, 0, 0);
    drive_bit(1); settle();
    head_and_pop("R3 framing entry"); head_and_pop("R3 resync entry");
    chk("R7 err after FE", int'(lsr[7]), 1);
    drain();

    // R4 long break, odd parity, single entry
    cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
    rxd = 1'b0; repeat (33 * BITCLK) @(negedge clk);
    mpush(0, 1, 1, 1);
    drive_bit(1); drive_bit(1); settle();
    head_and_pop("R4 break entry");
    chk("R4 break single", int'(lsr[0]), 0);
    drain();

    // R4 two stop bits: zero frame, low first stop, high second stop
    cfg_par_en = 1'b0; cfg_stop2 = 1'b1;
    drive_bit(0); send_bits(0, 8); drive_bit(0); drive_bit(1);
    mpush(0, 0, 1, 0); drive_bit(1); settle();
    head_and_pop("R4 stop2 framing only");
    drain();
    cfg_stop2 = 1'b0;

    // R7 summary bit persistence
    cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send_char(8'h0F, 1); send_char(8'h11, 0); drive_bit(1); settle();
    chk("R7 set on flagged push", int'(lsr[7]), 1);
    do_read(); settle();
    chk("R7 held while flagged queued", int'(lsr[7]), 1);
    head_and_pop("R7 flagged head");
    settle();
    chk("R7 still set before read", int'(lsr[7]), 1);
    do_read(); settle();
    chk("R7 cleared after read", int'(lsr[7]), 0);
    drain();

    // R5 overrun
    cfg_par_en = 1'b0;
    for (int i = 0; i < 17; i++) send_char(8'h30 + i, 0);
    drive_bit(1); settle();
    chk("R5 overrun set", int'(lsr[1]), 1);
    check_head("R5 head after overrun");
    do_read(); settle();
    chk("R5 overrun cleared", int'(lsr[1]), 0);
    for (int i = 0; i < 16; i++) begin
      chk("R1 order after overrun", int'(rx_data), 8'h30 + i);
      do_pop();
    end
    settle();
    chk("R5 dropped char absent", int'(lsr[0]), 0);

    // R8 pop on empty
    do_pop(); do_pop(); settle();
    chk("R8 empty pop lsr", int'(lsr), int'(exp_lsr()));
    send_char(8'hC3, 0); drive_bit(1); settle();
    head_and_pop("R8 after empty pops");

    chk("R6 per-clock status mismatches", mism, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule